// File: doc/BRIEF.md
# Current-Aware PWM Offset Selector

This block sits in front of the carrier comparators of a three-phase, five-level carrier-based modulator. Once per carrier period it takes the three phase control voltages, each between 0 and 4 in carrier units, together with the magnitudes of the three load currents. It then adds one common offset to all three voltages. The offset moves one phase exactly onto a carrier threshold, so that phase's switches stay still for the whole period. Adding the same value to every phase is a zero-sequence injection, so the line-to-line output is unchanged.

For each phase the block finds the carrier band that holds the voltage and the fractional position inside that band. The clamped phase is chosen from two rankings: the positions within their bands and the current magnitudes. The phase carrying the largest current is pinned when its position is the lowest or the highest of the three. When its position is the middle one, the phase with the second-largest current is pinned instead. That way, commutations are skipped on whichever of the two heavily loaded phases can be reached with the smaller shift.

Values are unsigned fixed point with 3 integer bits and 12 fractional bits, so 1.0 is code 4096 and 4.0 is code 16384. Inputs are captured on a strobe. The results appear two clock edges later and are held until the next strobe.

Top module: `pwm_ofs_sel`

## Requirements
- R1: While reset is asserted, and after it until the first strobe has taken effect, all three shifted outputs and the clamped-phase index read 0.
- R2: Inputs are captured at the clock edge where `smp_stb` is high. The outputs take the new result at the following edge. At every edge not preceded by a capture, the outputs keep their value whatever the inputs do.
- R3: A captured voltage above code 16384 (4.0) is treated as 4.0. The band floor is the integer part, limited to at most 3. The in-band error is the voltage minus the floor, so 4.0 lies in band 3 with error 1.0.
- R4: When the pinned phase has the lowest error of the three, the common offset is minus that error. The pinned phase's output then equals its band floor.
- R5: When the pinned phase has the highest error of the three, the common offset is 1.0 minus that error. The pinned phase's output then equals its band floor plus 1.0.
- R6: The pinned phase is the phase with the largest current magnitude, unless that phase holds the middle error. In that case it is the phase with the second-largest current magnitude.
- R7: In both rankings, equal values rank the lower phase index higher. Phase a (index 0) ranks before b (1), which ranks before c (2).
- R8: Each output is the captured voltage of its phase plus the common offset, limited to the range 0 to 16384.
- R9: `clamp_idx_o` gives the index of the pinned phase: 0 for a, 1 for b, 2 for c.
- R10: Inputs 4588, 2621 and 13271 (1.12, 0.64, 3.24) with current magnitudes a > b > c give outputs 4096, 2129 and 12779, and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Capture strobe, one pulse per carrier period |
| ctl_v | input | 3 x 15 | Control voltages of phases a, b, c (index 0, 1, 2), Q3.12 |
| cur_mag | input | 3 x 12 | Load-current magnitudes of phases a, b, c, unsigned |
| vr_o | output | 3 x 15 | Shifted control voltages, Q3.12 |
| clamp_idx_o | output | 2 | Index of the pinned phase |

## Verification
The in-design properties assume that a capture sees a voltage no higher than 4.0 after saturation. Under that assumption, the offset cannot push any phase outside 0 to 4 before the output limit is applied. The pinned phase must also land on a whole number of carrier units. Random stimulus draws voltages from 0 to 4.0 inclusive and, on purpose, often makes currents or in-band errors equal, so that the tie rules are exercised. Out-of-range voltages appear only in the directed saturation case. The strobe is always driven a full cycle apart from the sampling of the outputs.

// File: rtl/pwm_ofs_pkg.sv
package pwm_ofs_pkg;
  localparam int NPH    = 3;  // phases a, b, c
  localparam int LEVELS = 4;  // carrier bands between thresholds 0..4
  localparam int RW     = 2;  // width of a rank or phase index
  typedef logic [RW-1:0] rank_t;
endpackage

// File: rtl/pwm_ofs_band.sv
module pwm_ofs_band
  import pwm_ofs_pkg::*;
#(
  parameter int IBITS = 3,
  parameter int FBITS = 12
) (
  input  logic [IBITS+FBITS-1:0] v_i,
  output logic [FBITS:0]         err_o
);
  localparam int VW = IBITS + FBITS;

  function automatic logic [IBITS-1:0] f_floor(input logic [VW-1:0] v);
    logic [IBITS-1:0] ip;
    ip = v[VW-1:FBITS];
    return (int'(ip) >= LEVELS) ? IBITS'(LEVELS - 1) : ip;
  endfunction

  function automatic logic [FBITS:0] f_err(input logic [VW-1:0] v);
    logic [VW-1:0] d;
    d = v - {f_floor(v), {FBITS{1'b0}}};
    return d[FBITS:0];
  endfunction

  assign err_o = f_err(v_i);
endmodule

// File: rtl/pwm_ofs_rank.sv
module pwm_ofs_rank
  import pwm_ofs_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPH-1:0][W-1:0]   val_i,
  output rank_t [NPH-1:0]         rank_o
);
  // rank 0 is the largest; equal values rank the lower index higher
  function automatic rank_t f_rank(input logic [NPH-1:0][W-1:0] v, input int i);
    int n;
    n = 0;
    for (int j = 0; j < NPH; j++) begin
      if (j != i && ((v[j] > v[i]) || (v[j] == v[i] && j < i))) n++;
    end
    return RW'(n);
  endfunction

  for (genvar g = 0; g < NPH; g++) begin : g_rank
    assign rank_o[g] = f_rank(val_i, g);
  end

  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_o[0] != rank_o[1]) && (rank_o[1] != rank_o[2]) && (rank_o[0] != rank_o[2])
    && (int'(rank_o[0]) < NPH) && (int'(rank_o[1]) < NPH) && (int'(rank_o[2]) < NPH)); // R7
endmodule

// File: rtl/pwm_ofs_pick.sv
module pwm_ofs_pick
  import pwm_ofs_pkg::*;
#(
  parameter int FBITS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chk_en,
  input  rank_t [NPH-1:0]        cur_rank_i,
  input  rank_t [NPH-1:0]        err_rank_i,
  input  logic [NPH-1:0][FBITS:0] err_i,
  output rank_t                  pick_o,
  output logic signed [FBITS+1:0] off_o
);
  localparam int OW = FBITS + 2;
  localparam logic signed [OW-1:0] ONE = OW'(1 << FBITS);

  logic [NPH-1:0] imax, imed, emax, emed, emin, pv;
  logic           use_max, pin_low;
  logic [FBITS:0] err_p;

  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      imax[i] = (cur_rank_i[i] == RW'(0));
      imed[i] = (cur_rank_i[i] == RW'(1));
      emax[i] = (err_rank_i[i] == RW'(0));
      emed[i] = (err_rank_i[i] == RW'(1));
      emin[i] = (err_rank_i[i] == RW'(2));
    end
  end

  assign use_max = ~|(imax & emed);
  assign pv      = use_max ? imax : imed;
  assign pin_low = |(pv & emin);

  always_comb begin
    err_p  = '0;
    pick_o = '0;
    for (int i = 0; i < NPH; i++) begin
      if (pv[i]) begin
        err_p  = err_p | err_i[i];
        pick_o = RW'(i);
      end
    end
  end

  assign off_o = pin_low ? -$signed({1'b0, err_p}) : ONE - $signed({1'b0, err_p});

  AST_PICK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $countones(pv) == 1); // R6
  AST_PICK_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (pv & emed) == '0); // R6
endmodule

// File: rtl/pwm_ofs_sel.sv
module pwm_ofs_sel
  import pwm_ofs_pkg::*;
#(
  parameter int IBITS = 3,
  parameter int FBITS = 12,
  parameter int CW    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_stb,
  input  logic [NPH-1:0][IBITS+FBITS-1:0] ctl_v,
  input  logic [NPH-1:0][CW-1:0]        cur_mag,
  output logic [NPH-1:0][IBITS+FBITS-1:0] vr_o,
  output logic [RW-1:0]                 clamp_idx_o
);
  localparam int VW = IBITS + FBITS;
  localparam int OW = FBITS + 2;
  localparam int SW = VW + 2;
  localparam logic [VW-1:0] FULL = VW'(LEVELS << FBITS);

  function automatic logic [VW-1:0] f_sat(input logic [VW-1:0] v);
    return (v > FULL) ? FULL : v;
  endfunction

  function automatic logic [VW-1:0] f_limit(input logic signed [SW-1:0] s);
    if (s < 0)               return '0;
    else if (s > $signed({2'b00, FULL})) return FULL;
    else                     return s[VW-1:0];
  endfunction

  // stage 1: capture
  logic [NPH-1:0][VW-1:0] v_q;
  logic [NPH-1:0][CW-1:0] cur_q;
  logic                   s1_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      cur_q  <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= smp_stb;
      if (smp_stb) begin
        for (int i = 0; i < NPH; i++) begin
          v_q[i]   <= f_sat(ctl_v[i]);
          cur_q[i] <= cur_mag[i];
        end
      end
    end
  end

  // band positions
  logic [NPH-1:0][FBITS:0] err;
  for (genvar g = 0; g < NPH; g++) begin : g_band
    pwm_ofs_band #(.IBITS(IBITS), .FBITS(FBITS)) band_i (
      .v_i   (v_q[g]),
      .err_o (err[g])
    );
  end

  // rankings
  rank_t [NPH-1:0] cur_rank, err_rank;
  pwm_ofs_rank #(.W(CW)) cur_rank_i (
    .clk(clk), .rst_n(rst_n), .val_i(cur_q), .rank_o(cur_rank));
  pwm_ofs_rank #(.W(FBITS+1)) err_rank_i (
    .clk(clk), .rst_n(rst_n), .val_i(err), .rank_o(err_rank));

  // selection
  rank_t                 pick;
  logic signed [OW-1:0]  off;
  pwm_ofs_pick #(.FBITS(FBITS)) pick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (s1_vld),
    .cur_rank_i (cur_rank),
    .err_rank_i (err_rank),
    .err_i      (err),
    .pick_o     (pick),
    .off_o      (off)
  );

  // shift all phases
  logic signed [SW-1:0] sum [NPH];
  for (genvar g = 0; g < NPH; g++) begin : g_sum
    assign sum[g] = $signed({2'b00, v_q[g]}) + $signed({{(SW-OW){off[OW-1]}}, off});
    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |-> (sum[g] >= 0) && (sum[g] <= $signed({2'b00, FULL}))); // R8
  end

  // stage 2: results
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vr_o        <= '0;
      clamp_idx_o <= '0;
    end else if (s1_vld) begin
      for (int i = 0; i < NPH; i++) vr_o[i] <= f_limit(sum[i]);
      clamp_idx_o <= pick;
    end
  end

  AST_PIN_INTEGER: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> sum[pick][FBITS-1:0] == '0); // R4 R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(vr_o) && $stable(clamp_idx_o)); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(clamp_idx_o) < NPH); // R9
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_o[0] <= FULL) && (vr_o[1] <= FULL) && (vr_o[2] <= FULL)); // R8
endmodule

// File: tb/pwm_ofs_sel_tb_top.sv
module pwm_ofs_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [2:0][14:0] ctl_v = '0;
  logic [2:0][11:0] cur_mag = '0;
  logic [2:0][14:0] vr_o;
  logic [1:0]       clamp_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_v[3];
  int exp_idx;
  string exp_tag;

  always #10 clk = ~clk;  // 50 MHz

  pwm_ofs_sel dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ctl_v(ctl_v),
    .cur_mag(cur_mag), .vr_o(vr_o), .clamp_idx_o(clamp_idx_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference: computed from the requirements
  task automatic model(input int v0, input int v1, input int v2,
                       input int c0, input int c1, input int c2);
    int sv[3], er[3], cu[3];
    int imx, imd, o1, o2, emx, emn, p, off, s;
    sv[0] = v0; sv[1] = v1; sv[2] = v2;
    cu[0] = c0; cu[1] = c1; cu[2] = c2;
    for (int i = 0; i < 3; i++) begin
      int fl;
      if (sv[i] > 16384) sv[i] = 16384;
      fl = sv[i] / 4096;
      if (fl > 3) fl = 3;
      er[i] = sv[i] - fl * 4096;
    end
    imx = 0;
    for (int j = 1; j < 3; j++) if (cu[j] > cu[imx]) imx = j;
    o1 = (imx == 0) ? 1 : 0;
    o2 = (imx == 2) ? 1 : 2;
    imd = (cu[o2] > cu[o1]) ? o2 : o1;
    emx = 0;
    for (int j = 1; j < 3; j++) if (er[j] > er[emx]) emx = j;
    emn = 0;
    for (int j = 1; j < 3; j++) if (er[j] <= er[emn]) emn = j;
    if (imx != emx && imx != emn) begin p = imd; exp_tag = "R6"; end
    else begin p = imx; exp_tag = (imx == emn) ? "R4" : "R5"; end
    off = (p == emn) ? -er[p] : 4096 - er[p];
    for (int i = 0; i < 3; i++) begin
      s = sv[i] + off;
      exp_v[i] = (s < 0) ? 0 : (s > 16384) ? 16384 : s;
    end
    exp_idx = p;
  endtask

  task automatic apply(input int v0, input int v1, input int v2,
                       input int c0, input int c1, input int c2);
    @(negedge clk);
    ctl_v[0] = 15'(v0); ctl_v[1] = 15'(v1); ctl_v[2] = 15'(v2);
    cur_mag[0] = 12'(c0); cur_mag[1] = 12'(c1); cur_mag[2] = 12'(c2);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);  // capture edge then result edge have passed
  endtask

  task automatic run_cmp(input int v0, input int v1, input int v2,
                         input int c0, input int c1, input int c2, input string req);
    model(v0, v1, v2, c0, c1, c2);
    apply(v0, v1, v2, c0, c1, c2);
    for (int i = 0; i < 3; i++)
      chk(int'(vr_o[i]) == exp_v[i], {req, " ", exp_tag, " R8 out"}, int'(vr_o[i]), exp_v[i]);
    chk(int'(clamp_idx_o) == exp_idx, {req, " R9 idx"}, int'(clamp_idx_o), exp_idx);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 3; i++) chk(vr_o[i] == '0, "R1 reset out", int'(vr_o[i]), 0);
    chk(clamp_idx_o == '0, "R1 reset idx", int'(clamp_idx_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vr_o[0] == '0 && vr_o[1] == '0 && vr_o[2] == '0, "R1 after reset", int'(vr_o[0]), 0);

    // R10 worked example
    apply(4588, 2621, 13271, 900, 500, 100);
    chk(int'(vr_o[0]) == 4096,  "R10 a", int'(vr_o[0]), 4096);
    chk(int'(vr_o[1]) == 2129,  "R10 b", int'(vr_o[1]), 2129);
    chk(int'(vr_o[2]) == 12779, "R10 c", int'(vr_o[2]), 12779);
    chk(clamp_idx_o == 2'd0,    "R10 idx", int'(clamp_idx_o), 0);

    // R2 timing: one edge after capture nothing yet, then hold without strobe
    @(negedge clk);
    ctl_v[0] = 15'd6144; ctl_v[1] = 15'd1024; ctl_v[2] = 15'd9000;
    cur_mag[0] = 12'd10; cur_mag[1] = 12'd20; cur_mag[2] = 12'd30;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    chk(int'(vr_o[0]) == 4096, "R2 latency not early", int'(vr_o[0]), 4096);
    ctl_v[0] = 15'd100;
    repeat (4) @(negedge clk);
    model(6144, 1024, 9000, 10, 20, 30);
    chk(int'(vr_o[0]) == exp_v[0], "R2 result of captured inputs", int'(vr_o[0]), exp_v[0]);
    chk(int'(vr_o[2]) == exp_v[2], "R2 hold", int'(vr_o[2]), exp_v[2]);

    // R5 pinned phase on highest error: 2.75,1.25,0.5 -> 3.0,1.5,0.75
    run_cmp(11264, 5120, 2048, 300, 200, 100, "R5 directed");
    chk(int'(vr_o[0]) == 12288, "R5 pinned to upper edge", int'(vr_o[0]), 12288);
    // R6 handoff: a median error -> b (medium current, max error)
    run_cmp(6144, 11264, 1024, 300, 200, 100, "R6 directed");
    chk(clamp_idx_o == 2'd1, "R6 medium-current phase pinned", int'(clamp_idx_o), 1);
    // R4 pinned on lowest error
    run_cmp(5000, 9000, 14000, 10, 900, 20, "R4 directed");
    // R7 equal currents: a max, b medium; a median error -> b
    run_cmp(6144, 1024, 15360, 50, 50, 50, "R7 current tie");
    chk(clamp_idx_o == 2'd1, "R7 tie to lower index", int'(clamp_idx_o), 1);
    // R7 equal errors: a ranks max error -> offset +0.5
    run_cmp(6144, 6144, 6144, 70, 70, 70, "R7 error tie");
    chk(int'(vr_o[1]) == 8192, "R7 all shift to 2.0", int'(vr_o[1]), 8192);
    // R3 voltage 4.0 in band 3 with error 1.0 -> zero offset
    run_cmp(16384, 6144, 9216, 999, 5, 4, "R3 full scale");
    chk(int'(vr_o[0]) == 16384, "R3 4.0 unchanged", int'(vr_o[0]), 16384);
    // R3 saturation of an input above 4.0
    run_cmp(20480, 6144, 9216, 999, 5, 4, "R3 saturate");
    chk(int'(vr_o[0]) == 16384, "R3 saturated to 4.0", int'(vr_o[0]), 16384);
    // R8 low edge: zero input
    run_cmp(0, 4096, 8192, 40, 30, 20, "R8 zero");

    // random mix with forced ties
    for (int k = 0; k < 300; k++) begin
      int v[3], c[3];
      for (int i = 0; i < 3; i++) begin
        v[i] = $urandom_range(0, 16384);
        c[i] = $urandom_range(0, 4095);
      end
      if ($urandom_range(0, 3) == 0) c[1] = c[0];
      if ($urandom_range(0, 3) == 0) c[2] = c[$urandom_range(0, 1)];
      if ($urandom_range(0, 4) == 0) v[2] = (v[2] & 32'h3000) | (v[0] & 32'h0fff);
      if ($urandom_range(0, 7) == 0) v[$urandom_range(0, 2)] = 16384;
      run_cmp(v[0], v[1], v[2], c[0], c[1], c[2], "R7 random");
    end

    done = 1;
    finish_run();
  end
endmodule